// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM from power-up to a usable state. It waits in an idle state with the device deselected and clock enable low. A start pulse makes it raise clock enable and hold NOP for a programmable settling time, which is 100 µs or more in practice. It then issues a precharge of all banks, a programmable run of auto-refresh commands and a load of the device mode register. It keeps the row-precharge, row-cycle and mode-load-to-active spacings between those commands and finally raises a sticky done flag. Data transfer and periodic refresh belong to other blocks and start only once done is high.

The sequencer runs on the controller core clock. Its command slots follow an internal enable that fires once every `CLK_RATIO` core cycles (default 2), so the device sees one command per SDRAM clock at half the core rate. Every delay field and the refresh count are given as the required value minus one. The mode word is assembled from separate configuration fields. The state machine has these states:

- IDLE: deselect, CKE low.
- STABLE: CKE high, NOP, settling count.
- PRECHARGE: one command slot.
- REFRESH: one command slot.
- LOAD_MODE: one command slot.
- GAP: NOP while a spacing elapses.
- READY: NOP, done high.

The transitions are:

- IDLE→STABLE when start is pending.
- STABLE→PRECHARGE when the settling count expires.
- PRECHARGE→REFRESH, either directly or through GAP.
- REFRESH→REFRESH while refreshes remain, otherwise REFRESH→LOAD_MODE, in both cases directly or through GAP.
- LOAD_MODE→READY, directly or through GAP.
- GAP→its recorded target when the timer expires.
- READY holds until reset.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, and until a start pulse arrives, the outputs are held as follows: `sd_cke` low, the device deselected (`sd_cs_n`, `sd_ras_n`, `sd_cas_n`, `sd_we_n` all high), `sd_addr` and `sd_ba` zero, and `init_done` low.
- R2: A start pulse in the idle state raises `sd_cke`, which stays high until the next reset.
- R3: The first command after `sd_cke` rises is precharge-all, placed `cfg_stab_m1`+1 SDRAM clocks after the rise. Only NOP (CS# low, RAS#/CAS#/WE# high) is driven in between.
- R4: Precharge-all is encoded as CS#, RAS# and WE# low with CAS# high. `sd_addr` has only bit 10 set and `sd_ba` is 0.
- R5: Exactly `cfg_refresh_m1`+1 auto-refresh commands follow the precharge. Auto-refresh is encoded as CS#, RAS# and CAS# low with WE# high. The first one comes `cfg_trp_m1`+1 SDRAM clocks after the precharge.
- R6: Consecutive auto-refreshes are spaced `cfg_trc_m1`+1 SDRAM clocks apart. The load-mode command comes the same spacing after the last refresh.
- R7: Load-mode is encoded as CS#, RAS#, CAS# and WE# all low, with `sd_ba` 0. `sd_addr` carries the mode word in these fields:
  - bits [2:0]: burst length
  - bit 3: burst type
  - bits [6:4]: CAS latency
  - bits [8:7]: operating mode
  - bit 9: write-burst mode
  - all higher bits: zero
- R8: `init_done` rises `cfg_tmrd_m1`+1 SDRAM clocks after the load-mode command. It then stays high with NOP on the command pins until reset.
- R9: Every command occupies exactly `CLK_RATIO` (2) core clock cycles, so all spacings count in SDRAM clocks of two core cycles.
- R10: A start pulse while the sequence is running or finished has no effect. The command timing is unchanged and no further command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the power-up sequence (used only while idle) |
| cfg_stab_m1 | input | STAB_W (16) | Settling time after CKE, SDRAM clocks minus one |
| cfg_refresh_m1 | input | REF_W (4) | Number of auto-refreshes minus one |
| cfg_trp_m1 | input | TIM_W (4) | Precharge-to-command spacing minus one |
| cfg_trc_m1 | input | TIM_W (4) | Refresh-to-command spacing minus one |
| cfg_tmrd_m1 | input | TIM_W (4) | Mode-load-to-done spacing minus one |
| cfg_burst_len | input | 3 | Mode word burst length code |
| cfg_burst_interleave | input | 1 | Mode word burst type (0 = sequential) |
| cfg_cas_lat | input | 3 | Mode word CAS latency |
| cfg_op_mode | input | 2 | Mode word operating mode (0 = standard) |
| cfg_wr_single | input | 1 | Mode word write-burst mode (0 = programmed length) |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_addr | output | ADDR_W (13) | SDRAM address bus |
| sd_ba | output | BA_W (2) | SDRAM bank address |
| init_done | output | 1 | Initialization complete |

## Verification
The bench targets zero-valued delay fields, where a wait must be skipped entirely. A design with an off-by-one there would insert a stray NOP slot or let two commands merge. A single refresh, and back-to-back refreshes with no gap between them, catch a count that is off by one or a repeat that stops early; these show up as a missing or extra refresh or a load-mode arriving a slot early. A full 100 µs settling count and mode words with every field non-zero expose truncated timers and misplaced mode fields. Start pulses mid-sequence and after completion would, if honoured, restart the sequence or stretch its spacing, and the scoreboard would see extra commands.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Coded command field: the values 1..4 follow the initialization order.
    typedef enum logic [2:0] {
        CMD_NOP           = 3'd0,
        CMD_CKE_ON        = 3'd1,
        CMD_PRECHARGE_ALL = 3'd2,
        CMD_AUTO_REFRESH  = 3'd3,
        CMD_LOAD_MODE     = 3'd4,
        CMD_DESELECT      = 3'd5
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STABLE,
        ST_PRECHARGE,
        ST_REFRESH,
        ST_LOAD_MODE,
        ST_GAP,
        ST_READY
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_pins_t;

    localparam int MODE_BITS = 10;
    localparam int A10_POS   = 10;

endpackage

// File: rtl/sdram_phase_gen.sv
module sdram_phase_gen #(
    parameter int CLK_RATIO = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLK_RATIO > 1) ? $clog2(CLK_RATIO) : 1;

    generate
        if (CLK_RATIO == 1) begin : g_full_rate
            assign tick = 1'b1;
        end else begin : g_divided
            logic [CW-1:0] phase_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    phase_q <= '0;
                end else if (phase_q == CW'(CLK_RATIO - 1)) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end
            assign tick = (phase_q == CW'(CLK_RATIO - 1));
        end
    endgenerate

endmodule

// File: rtl/sdram_delay_timer.sv
module sdram_delay_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_mode_image.sv
module sdram_mode_image
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        burst_len,
    input  logic              burst_interleave,
    input  logic [2:0]        cas_lat,
    input  logic [1:0]        op_mode,
    input  logic              wr_single,
    output logic [ADDR_W-1:0] image
);
    logic [MODE_BITS-1:0] low_bits;

    assign low_bits = {wr_single, op_mode, cas_lat, burst_interleave, burst_len};

    generate
        if (ADDR_W > MODE_BITS) begin : g_pad
            assign image = {{(ADDR_W - MODE_BITS){1'b0}}, low_bits};
        end else begin : g_exact
            assign image = low_bits[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/sdram_cmd_encode.sv
module sdram_cmd_encode
    import sdram_init_pkg::*;
(
    input  sd_cmd_e  cmd,
    output sd_pins_t pins
);
    always_comb begin
        unique case (cmd)
            CMD_DESELECT:      pins = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_PRECHARGE_ALL: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_AUTO_REFRESH:  pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_LOAD_MODE:     pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            CMD_CKE_ON,
            CMD_NOP:           pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            default:           pins = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_RATIO = 2,
    parameter int STAB_W    = 16,
    parameter int REF_W     = 4,
    parameter int TIM_W     = 4,
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [STAB_W-1:0] cfg_stab_m1,
    input  logic [REF_W-1:0]  cfg_refresh_m1,
    input  logic [TIM_W-1:0]  cfg_trp_m1,
    input  logic [TIM_W-1:0]  cfg_trc_m1,
    input  logic [TIM_W-1:0]  cfg_tmrd_m1,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [1:0]        cfg_op_mode,
    input  logic              cfg_wr_single,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              init_done
);
    localparam int TMR_W = (STAB_W > TIM_W) ? STAB_W : TIM_W;

    seq_state_e        state_q, state_d;
    seq_state_e        gap_next_q, gap_next_d;
    logic [REF_W-1:0]  refresh_left_q, refresh_left_d;
    logic              start_pend_q;
    logic              tick;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              leave;
    logic [TIM_W-1:0]  leave_m1;
    seq_state_e        leave_to;
    sd_cmd_e           cmd;
    sd_pins_t          pins;
    logic [ADDR_W-1:0] mode_word;

    sdram_phase_gen #(.CLK_RATIO(CLK_RATIO)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sdram_delay_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdram_mode_image #(.ADDR_W(ADDR_W)) u_mode (
        .burst_len        (cfg_burst_len),
        .burst_interleave (cfg_burst_interleave),
        .cas_lat          (cfg_cas_lat),
        .op_mode          (cfg_op_mode),
        .wr_single        (cfg_wr_single),
        .image            (mode_word)
    );

    sdram_cmd_encode u_enc (
        .cmd  (cmd),
        .pins (pins)
    );

    // Start is remembered only while idle so a one-cycle pulse between
    // command slots is not lost; any other state ignores it.
    always_ff @(posedge clk) begin
        if (rst) begin
            start_pend_q <= 1'b0;
        end else if (state_q != ST_IDLE) begin
            start_pend_q <= 1'b0;
        end else if (start) begin
            start_pend_q <= 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            gap_next_q     <= ST_READY;
            refresh_left_q <= '0;
        end else begin
            state_q        <= state_d;
            gap_next_q     <= gap_next_d;
            refresh_left_q <= refresh_left_d;
        end
    end

    // Next-state logic: moves only on command-slot boundaries
    always_comb begin
        state_d        = state_q;
        gap_next_d     = gap_next_q;
        refresh_left_d = refresh_left_q;
        tmr_load       = 1'b0;
        tmr_val        = '0;
        leave          = 1'b0;
        leave_m1       = '0;
        leave_to       = ST_READY;
        if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_pend_q) begin
                        state_d        = ST_STABLE;
                        tmr_load       = 1'b1;
                        tmr_val        = TMR_W'(cfg_stab_m1);
                        refresh_left_d = cfg_refresh_m1;
                    end
                end
                ST_STABLE: begin
                    if (tmr_expired) begin
                        state_d = ST_PRECHARGE;
                    end
                end
                ST_PRECHARGE: begin
                    leave    = 1'b1;
                    leave_m1 = cfg_trp_m1;
                    leave_to = ST_REFRESH;
                end
                ST_REFRESH: begin
                    leave    = 1'b1;
                    leave_m1 = cfg_trc_m1;
                    if (refresh_left_q == '0) begin
                        leave_to = ST_LOAD_MODE;
                    end else begin
                        leave_to       = ST_REFRESH;
                        refresh_left_d = refresh_left_q - 1'b1;
                    end
                end
                ST_LOAD_MODE: begin
                    leave    = 1'b1;
                    leave_m1 = cfg_tmrd_m1;
                    leave_to = ST_READY;
                end
                ST_GAP: begin
                    if (tmr_expired) begin
                        state_d = gap_next_q;
                    end
                end
                ST_READY: begin
                    state_d = ST_READY;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
            // A field of zero means the next command takes the very next slot.
            if (leave) begin
                if (leave_m1 == '0) begin
                    state_d = leave_to;
                end else begin
                    state_d    = ST_GAP;
                    gap_next_d = leave_to;
                    tmr_load   = 1'b1;
                    tmr_val    = TMR_W'(leave_m1 - 1'b1);
                end
            end
        end
    end

    // Output logic (Moore, from the state register)
    always_comb begin
        cmd       = CMD_NOP;
        sd_cke    = 1'b1;
        init_done = 1'b0;
        sd_addr   = '0;
        sd_ba     = '0;
        unique case (state_q)
            ST_IDLE: begin
                cmd    = CMD_DESELECT;
                sd_cke = 1'b0;
            end
            ST_STABLE:    cmd = CMD_CKE_ON;
            ST_PRECHARGE: begin
                cmd              = CMD_PRECHARGE_ALL;
                sd_addr[A10_POS] = 1'b1;
            end
            ST_REFRESH:   cmd = CMD_AUTO_REFRESH;
            ST_LOAD_MODE: begin
                cmd     = CMD_LOAD_MODE;
                sd_addr = mode_word;
            end
            ST_GAP:       cmd = CMD_NOP;
            ST_READY: begin
                cmd       = CMD_NOP;
                init_done = 1'b1;
            end
            default: begin
                cmd    = CMD_DESELECT;
                sd_cke = 1'b0;
            end
        endcase
    end

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [BA_W-1:0]   sd_ba,
    input logic              init_done
);
    logic active, is_pre, is_lmr, is_nop, seen_lmr_q, odd_q;

    assign active = !sd_cs_n && !(sd_ras_n && sd_cas_n && sd_we_n);
    assign is_pre = !sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n;
    assign is_lmr = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;
    assign is_nop = !sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_lmr_q <= 1'b0;
            odd_q      <= 1'b0;
        end else begin
            if (is_lmr) seen_lmr_q <= 1'b1;
            odd_q <= active ? ~odd_q : 1'b0;
        end
    end

    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (rst)
        !sd_cke |-> (sd_cs_n && !init_done && sd_addr == '0 && sd_ba == '0));

    assert_cke_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        sd_cke |=> sd_cke);

    assert_cmd_after_cke_R3: assert property (@(posedge clk) disable iff (rst)
        active |-> sd_cke);

    assert_pre_a10_R4: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> (sd_addr == ADDR_W'(1 << 10) && sd_ba == '0));

    assert_lmr_bank0_R7: assert property (@(posedge clk) disable iff (rst)
        is_lmr |-> (sd_ba == '0));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_done_after_lmr_R8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> seen_lmr_q);

    assert_done_nop_R8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (is_nop && sd_cke));

    assert_cmd_even_R9: assert property (@(posedge clk) disable iff (rst)
        (!active && $past(active)) |-> !odd_q);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_addr   (sd_addr),
    .sd_ba     (sd_ba),
    .init_done (init_done)
);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] cfg_stab_m1 = '0;
    logic [3:0]  cfg_refresh_m1 = '0;
    logic [3:0]  cfg_trp_m1 = '0;
    logic [3:0]  cfg_trc_m1 = '0;
    logic [3:0]  cfg_tmrd_m1 = '0;
    logic [2:0]  cfg_burst_len = '0;
    logic        cfg_burst_interleave = 1'b0;
    logic [2:0]  cfg_cas_lat = '0;
    logic [1:0]  cfg_op_mode = '0;
    logic        cfg_wr_single = 1'b0;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_addr;
    logic [1:0]  sd_ba;
    logic        init_done;

    always #2 clk = ~clk;

    sdram_init_seq u0 (
        .clk(clk), .rst(rst), .start(start),
        .cfg_stab_m1(cfg_stab_m1), .cfg_refresh_m1(cfg_refresh_m1),
        .cfg_trp_m1(cfg_trp_m1), .cfg_trc_m1(cfg_trc_m1), .cfg_tmrd_m1(cfg_tmrd_m1),
        .cfg_burst_len(cfg_burst_len), .cfg_burst_interleave(cfg_burst_interleave),
        .cfg_cas_lat(cfg_cas_lat), .cfg_op_mode(cfg_op_mode), .cfg_wr_single(cfg_wr_single),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba), .init_done(init_done)
    );

    // Event codes: 1 CKE rise, 2 precharge-all, 3 auto-refresh, 4 load-mode, 5 done rise
    typedef struct {
        int    code;
        int    addr;
        int    ba;
        int    gap;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   vectors = 0;
    int   errors  = 0;
    int   cyc     = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int code, input int addr, input int ba, input int gap, input string req);
        exp_t e;
        e.code = code; e.addr = addr; e.ba = ba; e.gap = gap; e.req = req;
        exp_q.push_back(e);
    endtask

    // ---------------- monitor ----------------
    int last_cyc = 0;

    task automatic got(input int code, input int addr, input int ba);
        exp_t e;
        int   gap;
        bit   ok;
        gap = cyc - last_cyc;
        last_cyc = cyc;
        vectors++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R10 unexpected event: actual code %0d expected none", code);
            return;
        end
        e = exp_q.pop_front();
        ok = (code == e.code) && (e.gap < 0 || gap == e.gap);
        if (e.code == 2 || e.code == 4) ok = ok && (addr == e.addr) && (ba == e.ba);
        if (!ok) begin
            errors++;
            $display("FAIL %s event: actual code %0d addr 0x%0h ba %0d gap %0d expected code %0d addr 0x%0h ba %0d gap %0d",
                     e.req, code, addr, ba, gap, e.code, e.addr, e.ba, e.gap);
        end
    endtask

    function automatic int decode_cmd();
        if (sd_cs_n) return 0;
        case ({sd_ras_n, sd_cas_n, sd_we_n})
            3'b111:  return 0;
            3'b010:  return 2;
            3'b001:  return 3;
            3'b000:  return 4;
            default: return 7;
        endcase
    endfunction

    bit prev_cke = 0, prev_rdy = 0;
    int prev_code = 0, run_len = 0;

    always @(negedge clk) begin
        int cur;
        if (rst) begin
            prev_cke = 0; prev_rdy = 0; prev_code = 0; run_len = 0; last_cyc = cyc;
        end else begin
            cur = decode_cmd();
            if (prev_code != 0 && cur != prev_code)   // R9: command run ends
                check(run_len % 2 == 0, "R9", "command length in core cycles", run_len, 2);
            if (!prev_cke && sd_cke) got(1, 0, 0);
            if (cur != 0) begin
                run_len = (cur == prev_code) ? run_len + 1 : 1;
                if (run_len % 2 == 1) got(cur, int'(sd_addr), int'(sd_ba));
            end else begin
                run_len = 0;
            end
            if (!prev_rdy && init_done) got(5, 0, 0);
            if (prev_rdy && !init_done)
                check(1'b0, "R8", "init_done fell", 0, 1);
            prev_cke  = sd_cke;
            prev_rdy  = init_done;
            prev_code = cur;
        end
    end

    // ---------------- driver ----------------
    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_seq(input int stab, input int nref_m1, input int trp, input int trc,
                           input int tmrd, input int bl, input int bt, input int cas,
                           input int op, input int wb, input bit poke);
        int img;
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cfg_stab_m1 = 16'(stab); cfg_refresh_m1 = 4'(nref_m1);
        cfg_trp_m1 = 4'(trp); cfg_trc_m1 = 4'(trc); cfg_tmrd_m1 = 4'(tmrd);
        cfg_burst_len = 3'(bl); cfg_burst_interleave = 1'(bt); cfg_cas_lat = 3'(cas);
        cfg_op_mode = 2'(op); cfg_wr_single = 1'(wb);
        repeat (20) @(negedge clk);
        // R1: idle after reset and without a start pulse
        check(sd_cke == 1'b0, "R1", "sd_cke idle", int'(sd_cke), 0);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b1111, "R1", "deselect pins",
              int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 15);
        check(init_done == 1'b0 && sd_addr == '0, "R1", "done/addr idle",
              int'({init_done, sd_addr}), 0);

        img = bl | (bt << 3) | (cas << 4) | (op << 7) | (wb << 9);
        push(1, 0, 0, -1, "R2");
        push(2, 32'h400, 0, 2 * (stab + 1), "R3");
        for (int i = 0; i <= nref_m1; i++)
            push(3, 0, 0, (i == 0) ? 2 * (trp + 1) : 2 * (trc + 1), (i == 0) ? "R5" : "R6");
        push(4, img, 0, 2 * (trc + 1), "R7");
        push(5, 0, 0, 2 * (tmrd + 1), "R8");

        pulse_start();
        if (poke) begin
            repeat (7) @(negedge clk);
            pulse_start();            // R10: ignored while running
            repeat (3) @(negedge clk);
            pulse_start();
        end
        while (!init_done) @(negedge clk);
        repeat (5) @(negedge clk);
        pulse_start();                // R10: ignored once ready
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R5", "events left in scoreboard", exp_q.size(), 0);
        check(init_done && sd_cke, "R10", "still ready after late start",
              int'({init_done, sd_cke}), 3);
        exp_q.delete();
    endtask

    initial begin
        // Full 100 us settling at a 125 MHz SDRAM clock, 8 refreshes, CAS 2
        run_seq(12499, 7, 1, 5, 1, 0, 0, 2, 0, 0, 1'b0);
        // All spacings zero, two back-to-back refreshes, busy mode word
        run_seq(0, 1, 0, 0, 0, 3, 1, 3, 0, 1, 1'b1);
        // Single-digit spacings, three refreshes, starts mid-sequence
        run_seq(5, 2, 2, 3, 3, 7, 0, 2, 3, 0, 1'b1);
        // Single refresh
        run_seq(2, 0, 1, 1, 2, 1, 1, 3, 1, 1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule